// File: doc/BRIEF.md
# Read Beat Merger for a Width-Down Converter

This block sits on the read-data return path of a converter that joins a wide manager to a narrower subordinate. Read data comes back as narrow beats. The block packs each transfer's narrow beats into one wide beat. Before the first narrow beat of a burst, a command input supplies the burst's context: the starting byte offset within the wide word, the transfer size and the transaction ID. The narrow side carries no ID; the block holds the ID and presents it with every wide beat. No user sideband is carried.

Each narrow beat is written into the wide-word slot chosen by a running byte offset. The offset starts at the command's address bits and advances by the smaller of the transfer size and the narrow width. A wide beat closes when the offset reaches a transfer-size boundary, or when the narrow beat flagged last arrives. The wide beat's response is the most severe response among its narrow beats.

A small state machine sequences the work. It has three states. `S_IDLE` accepts a command. `S_GATHER` absorbs narrow beats. `S_ISSUE` presents a wide beat and holds it until it is taken. The transitions are:
- IDLE→GATHER when a command is accepted.
- GATHER→ISSUE when a closing narrow beat is absorbed.
- ISSUE→GATHER when a non-final wide beat is taken.
- ISSUE→IDLE when the final wide beat is taken.

Top module: `rd_beat_merger`

## Requirements
- R1: During and right after reset, `cmd_ready` is 1, `n_ready` is 0 and `w_valid` is 0.
- R2: A command is accepted only in the idle state. The cycle after it is accepted, `cmd_ready` is 0 and `n_ready` is 1. `cmd_ready` is never high together with `n_ready` or `w_valid`.
- R3: A narrow beat is placed in the 32-bit slot of `w_data` indexed by offset bits [3:2]. Slot k occupies bits [32k+31:32k]. Slots that no narrow beat of the current wide beat wrote read as zero.
- R4: When `cmd_size` (log2 of bytes) exceeds 2, the offset advances by 4 bytes per narrow beat. A wide beat closes only when the offset reaches a multiple of 2^size. An aligned transfer therefore takes 2^size/4 narrow beats, and an unaligned first transfer takes fewer. No wide beat appears before the transfer is complete.
- R5: When `cmd_size` is 2 or less, every narrow beat produces exactly one wide beat, and the offset advances by 2^size bytes.
- R6: Response codes are OKAY=0, EXOKAY=1, SLVERR=2 and DECERR=3. `w_resp` is the most severe response among the narrow beats of that wide beat, in the order DECERR > SLVERR > OKAY > EXOKAY. The accumulation restarts with every wide beat.
- R7: `w_last` is 1 only on the wide beat that contains the narrow beat flagged `n_last`. After that beat is taken, the block returns to idle.
- R8: `w_id` equals the `cmd_id` of the current burst on every wide beat.
- R9: While `w_valid` is 1 and `w_ready` is 0, `n_ready` is 0 and all `w_*` outputs hold steady. No narrow beat is lost or repeated.
- R10: `w_valid` rises in the cycle after the closing narrow beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Burst context valid |
| cmd_ready | output | 1 | Block is idle and takes a command |
| cmd_addr | input | WB_LOG (4) | Starting byte offset within the wide word |
| cmd_size | input | 3 | log2 of transfer size in bytes |
| cmd_id | input | ID_W (4) | Transaction ID for the burst |
| n_valid | input | 1 | Narrow beat valid |
| n_ready | output | 1 | Narrow beat accepted |
| n_data | input | NW (32) | Narrow beat data |
| n_resp | input | 2 | Narrow beat response |
| n_last | input | 1 | Final narrow beat of the burst |
| w_valid | output | 1 | Wide beat valid |
| w_ready | input | 1 | Wide side takes the beat |
| w_data | output | WW (128) | Packed wide data |
| w_resp | output | 2 | Merged response |
| w_last | output | 1 | Final wide beat of the burst |
| w_id | output | ID_W (4) | Held transaction ID |

## Verification
Each result has a fixed due time:
- `cmd_ready` falls and `n_ready` rises one cycle after a command is accepted.
- A wide beat becomes visible one cycle after its closing narrow beat is accepted, through a single state register.
- `cmd_ready` returns one cycle after the final wide beat is taken.

The bench drives inputs on falling edges and samples on the falling edge after each acceptance. Every data, response, last and ID check is therefore made in the exact cycle the result is due. It also checks that `w_valid` is still low after each non-closing beat, and that held outputs stay put for several stalled cycles.

// File: rtl/rdm_pkg.sv
package rdm_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_GATHER = 2'd1,
        S_ISSUE  = 2'd2
    } rdm_state_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_EXOKAY = 2'b01;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
    localparam logic [1:0] RESP_DECERR = 2'b11;

    // Severity rank: higher is worse.
    function automatic logic [1:0] resp_rank(input logic [1:0] r);
        unique case (r)
            RESP_DECERR: resp_rank = 2'd3;
            RESP_SLVERR: resp_rank = 2'd2;
            RESP_OKAY:   resp_rank = 2'd1;
            default:     resp_rank = 2'd0;
        endcase
    endfunction

    function automatic logic [1:0] resp_worse(input logic [1:0] a, input logic [1:0] b);
        resp_worse = (resp_rank(a) >= resp_rank(b)) ? a : b;
    endfunction

endpackage

// File: rtl/rdm_offset.sv
module rdm_offset #(
    parameter int NB_LOG = 2,
    parameter int WB_LOG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WB_LOG-1:0] start_off,
    input  logic [2:0]        start_size,
    input  logic              step_en,
    output logic [WB_LOG-1:0] cur_off,
    output logic              boundary
);
    localparam int EXT_W = WB_LOG + 1;

    logic [WB_LOG-1:0] off_q;
    logic [2:0]        size_q;
    logic [2:0]        step_log;
    logic [EXT_W-1:0]  step;
    logic [EXT_W-1:0]  aligned;
    logic [EXT_W-1:0]  nxt;
    logic [EXT_W-1:0]  size_mask;

    always_comb begin
        step_log  = (size_q > 3'(NB_LOG)) ? 3'(NB_LOG) : size_q;
        step      = EXT_W'(1) << step_log;
        aligned   = {1'b0, off_q} & ~(step - EXT_W'(1));
        nxt       = aligned + step;
        size_mask = (EXT_W'(1) << size_q) - EXT_W'(1);
        boundary  = ((nxt & size_mask) == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= '0;
            size_q <= '0;
        end else if (load) begin
            off_q  <= start_off;
            size_q <= start_size;
        end else if (step_en) begin
            off_q  <= nxt[WB_LOG-1:0];
        end
    end

    assign cur_off = off_q;

endmodule

// File: rtl/rdm_pack.sv
module rdm_pack
    import rdm_pkg::*;
#(
    parameter int NW = 32,
    parameter int WW = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         absorb,
    input  logic [$clog2(WW/NW)-1:0]     slot,
    input  logic [NW-1:0]                in_data,
    input  logic [1:0]                   in_resp,
    output logic [WW-1:0]                out_data,
    output logic [1:0]                   out_resp
);
    localparam int SLOTS  = WW / NW;
    localparam int SLOT_W = $clog2(SLOTS);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [NW-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                lane_q <= '0;
            end else if (absorb && slot == SLOT_W'(s)) begin
                lane_q <= in_data;
            end
        end
        assign out_data[s*NW +: NW] = lane_q;
    end

    logic [1:0] acc_q;
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q <= RESP_EXOKAY;
        end else if (absorb) begin
            acc_q <= resp_worse(acc_q, in_resp);
        end
    end
    assign out_resp = acc_q;

endmodule

// File: rtl/rd_beat_merger.sv
module rd_beat_merger
    import rdm_pkg::*;
#(
    parameter int NW   = 32,
    parameter int WW   = 128,
    parameter int ID_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    output logic                      cmd_ready,
    input  logic [$clog2(WW/8)-1:0]   cmd_addr,
    input  logic [2:0]                cmd_size,
    input  logic [ID_W-1:0]           cmd_id,
    input  logic                      n_valid,
    output logic                      n_ready,
    input  logic [NW-1:0]             n_data,
    input  logic [1:0]                n_resp,
    input  logic                      n_last,
    output logic                      w_valid,
    input  logic                      w_ready,
    output logic [WW-1:0]             w_data,
    output logic [1:0]                w_resp,
    output logic                      w_last,
    output logic [ID_W-1:0]           w_id
);
    localparam int NB_LOG = $clog2(NW / 8);
    localparam int WB_LOG = $clog2(WW / 8);
    localparam int SLOT_W = WB_LOG - NB_LOG;

    rdm_state_e state_q, state_d;

    logic              cmd_fire, n_fire, w_fire;
    logic              boundary;
    logic [WB_LOG-1:0] cur_off;
    logic [ID_W-1:0]   id_q;
    logic              last_q;

    assign cmd_fire = cmd_valid && cmd_ready;
    assign n_fire   = n_valid && n_ready;
    assign w_fire   = w_valid && w_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (cmd_valid)                        state_d = S_GATHER;
            S_GATHER: if (n_valid && (boundary || n_last))  state_d = S_ISSUE;
            S_ISSUE:  if (w_ready)                          state_d = last_q ? S_IDLE : S_GATHER;
            default:                                        state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_ready = 1'b0;
        n_ready   = 1'b0;
        w_valid   = 1'b0;
        unique case (state_q)
            S_IDLE:   cmd_ready = 1'b1;
            S_GATHER: n_ready   = 1'b1;
            S_ISSUE:  w_valid   = 1'b1;
            default:  ;
        endcase
    end

    // Burst context held for the active burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q   <= '0;
            last_q <= 1'b0;
        end else if (cmd_fire) begin
            id_q   <= cmd_id;
            last_q <= 1'b0;
        end else if (n_fire && n_last) begin
            last_q <= 1'b1;
        end
    end

    rdm_offset #(
        .NB_LOG (NB_LOG),
        .WB_LOG (WB_LOG)
    ) u_offset (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cmd_fire),
        .start_off  (cmd_addr),
        .start_size (cmd_size),
        .step_en    (n_fire),
        .cur_off    (cur_off),
        .boundary   (boundary)
    );

    rdm_pack #(
        .NW (NW),
        .WW (WW)
    ) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cmd_fire || w_fire),
        .absorb   (n_fire),
        .slot     (cur_off[WB_LOG-1 -: SLOT_W]),
        .in_data  (n_data),
        .in_resp  (n_resp),
        .out_data (w_data),
        .out_resp (w_resp)
    );

    assign w_last = last_q;
    assign w_id   = id_q;

endmodule

// File: rtl/rdm_checker.sv
module rdm_checker #(
    parameter int WW   = 128,
    parameter int ID_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_ready,
    input logic            n_valid,
    input logic            n_ready,
    input logic            n_last,
    input logic            w_valid,
    input logic            w_ready,
    input logic [WW-1:0]   w_data,
    input logic [1:0]      w_resp,
    input logic            w_last,
    input logic [ID_W-1:0] w_id
);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid && !w_ready |=> w_valid && $stable(w_data) && $stable(w_resp)
                                && $stable(w_last) && $stable(w_id));

    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid |-> !n_ready);

    assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !n_ready && !w_valid);

    assert_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        n_valid && n_ready && n_last |=> w_valid && w_last);

    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid && w_ready && w_last |=> cmd_ready);

    assert_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
        n_valid && n_ready |=> w_valid || n_ready);

endmodule

bind rd_beat_merger rdm_checker #(.WW(WW), .ID_W(ID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .n_valid   (n_valid),
    .n_ready   (n_ready),
    .n_last    (n_last),
    .w_valid   (w_valid),
    .w_ready   (w_ready),
    .w_data    (w_data),
    .w_resp    (w_resp),
    .w_last    (w_last),
    .w_id      (w_id)
);

// File: tb/rd_beat_merger_bench.sv
module rd_beat_merger_bench;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         cmd_valid, cmd_ready;
    logic [3:0]   cmd_addr;
    logic [2:0]   cmd_size;
    logic [3:0]   cmd_id;
    logic         n_valid, n_ready, n_last;
    logic [31:0]  n_data;
    logic [1:0]   n_resp;
    logic         w_valid, w_ready, w_last;
    logic [127:0] w_data;
    logic [1:0]   w_resp;
    logic [3:0]   w_id;

    int n_chk = 0;
    int n_bad = 0;

    always #10ns clk = ~clk;

    rd_beat_merger u_rd_beat_merger (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_size(cmd_size), .cmd_id(cmd_id),
        .n_valid(n_valid), .n_ready(n_ready), .n_data(n_data),
        .n_resp(n_resp), .n_last(n_last),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
        .w_resp(w_resp), .w_last(w_last), .w_id(w_id)
    );

    typedef struct packed {
        logic [3:0] addr;
        logic [2:0] size;
        logic [2:0] nb;
        logic [7:0] rs;
        logic [1:0] er;
    } vec_t;

    // One-wide-beat bursts: offset, size, narrow beats, packed responses, expected merged response
    localparam vec_t VEC [8] = '{
        '{4'd0,  3'd4, 3'd4, 8'h00, 2'd0},
        '{4'd0,  3'd4, 3'd4, 8'h55, 2'd1},
        '{4'd0,  3'd4, 3'd4, 8'h18, 2'd2},
        '{4'd8,  3'd3, 3'd2, 8'h0E, 2'd3},
        '{4'd4,  3'd2, 3'd1, 8'h01, 2'd1},
        '{4'd0,  3'd3, 3'd2, 8'h01, 2'd0},
        '{4'd12, 3'd2, 3'd1, 8'h03, 2'd3},
        '{4'd6,  3'd1, 3'd1, 8'h00, 2'd0}
    };

    function automatic logic [127:0] place(input int slot, input logic [31:0] d);
        return 128'(d) << (slot * 32);
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [3:0] a, input logic [2:0] s, input logic [3:0] id);
        cmd_valid = 1'b1; cmd_addr = a; cmd_size = s; cmd_id = id;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic push(input logic [31:0] d, input logic [1:0] r, input logic l);
        n_valid = 1'b1; n_data = d; n_resp = r; n_last = l;
        while (!n_ready) @(negedge clk);
        @(negedge clk);
        n_valid = 1'b0; n_last = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] exp_d;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_size = '0; cmd_id = '0;
        n_valid = 1'b0; n_data = '0; n_resp = '0; n_last = 1'b0; w_ready = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 cmd_ready in reset", 128'(cmd_ready), 128'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cmd_ready", 128'(cmd_ready), 128'd1);
        check("R1 n_ready", 128'(n_ready), 128'd0);
        check("R1 w_valid", 128'(w_valid), 128'd0);

        // Table walk
        for (int i = 0; i < 8; i++) begin
            send_cmd(VEC[i].addr, VEC[i].size, 4'(i + 3));
            check("R2 cmd_ready low after accept", 128'(cmd_ready), 128'd0);
            check("R2 n_ready high after accept", 128'(n_ready), 128'd1);
            exp_d = '0;
            for (int k = 0; k < int'(VEC[i].nb); k++) begin
                logic [31:0] d;
                d = 32'hC0DE_0000 + 32'(i * 16 + k);
                exp_d |= place(int'(VEC[i].addr[3:2]) + k, d);
                push(d, VEC[i].rs[2*k +: 2], k == int'(VEC[i].nb) - 1);
                if (k < int'(VEC[i].nb) - 1)
                    check("R4 no early wide beat", 128'(w_valid), 128'd0);
            end
            check("R10 w_valid after closing beat", 128'(w_valid), 128'd1);
            check("R3 packed data", w_data, exp_d);
            check("R6 merged resp", 128'(w_resp), 128'(VEC[i].er));
            check("R7 last flag", 128'(w_last), 128'd1);
            check("R8 id", 128'(w_id), 128'(i + 3));
            @(negedge clk);
            check("R7 back to idle", 128'(cmd_ready), 128'd1);
        end

        // Narrow size: one wide beat per narrow beat, response restarts each beat
        send_cmd(4'd4, 3'd2, 4'd9);
        for (int k = 0; k < 3; k++) begin
            logic [1:0] r;
            r = (k == 0) ? 2'd3 : (k == 1) ? 2'd0 : 2'd1;
            push(32'h5500_0000 + 32'(k), r, k == 2);
            check("R5 wide beat per narrow beat", 128'(w_valid), 128'd1);
            check("R5 slot advance", w_data, place(k + 1, 32'h5500_0000 + 32'(k)));
            check("R6 resp restarts per beat", 128'(w_resp), 128'(r));
            check("R7 last only on final", 128'(w_last), 128'(k == 2));
            check("R8 id held", 128'(w_id), 128'd9);
            @(negedge clk);
        end

        // Unaligned wide transfer: first wide beat holds one narrow beat
        send_cmd(4'd4, 3'd3, 4'd2);
        push(32'hAAAA_0001, 2'd2, 1'b0);
        check("R4 unaligned first closes early", 128'(w_valid), 128'd1);
        check("R4 unaligned first data", w_data, place(1, 32'hAAAA_0001));
        check("R7 not last", 128'(w_last), 128'd0);
        @(negedge clk);
        push(32'hAAAA_0002, 2'd1, 1'b0);
        check("R4 second transfer still open", 128'(w_valid), 128'd0);
        push(32'hAAAA_0003, 2'd1, 1'b1);
        check("R4 second transfer data", w_data,
              place(2, 32'hAAAA_0002) | place(3, 32'hAAAA_0003));
        check("R6 all EXOKAY stays EXOKAY", 128'(w_resp), 128'd1);
        @(negedge clk);

        // Back-pressure
        w_ready = 1'b0;
        send_cmd(4'd0, 3'd2, 4'd5);
        push(32'h1234_5678, 2'd2, 1'b1);
        for (int c = 0; c < 3; c++) begin
            check("R9 held valid", 128'(w_valid), 128'd1);
            check("R9 narrow stalled", 128'(n_ready), 128'd0);
            check("R9 held data", w_data, place(0, 32'h1234_5678));
            check("R9 held resp", 128'(w_resp), 128'd2);
            @(negedge clk);
        end
        w_ready = 1'b1;
        @(negedge clk);
        check("R9 released", 128'(w_valid), 128'd0);
        check("R7 idle after release", 128'(cmd_ready), 128'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule